// File: doc/BRIEF.md
# Flit CRC generator and checker

This block protects each link-layer flit with an 8-bit cyclic check. On the send side it takes 72 content bits (64 payload and 8 control), computes their remainder under the polynomial x^8 + x^7 + x^2 + 1, and spreads the 8 check bits over the four 20-bit phits of an 80-bit flit, two per phit. On the receive side it takes an 80-bit flit, splits it back into content and check bits, recomputes the remainder and flags a mismatch.

A shared mode input selects rolling operation. In that mode, the check field sent for a flit is its own remainder XOR the remainder of the flit sent before it. The receiver keeps the matching history taken from the received check fields, so the two ends chain flits into a longer code. Both ends are meant to be configured alike. Retransmission and correction are left to the surrounding logic.

Top module: `flit_crc_link`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `tx_out_valid`, `rx_chk_valid` and `rx_err` are 0.
- R2: The remainder is content(x)·x^8 mod (x^8 + x^7 + x^2 + 1). The register is preset to zero for every flit, and content bit 71 is the highest-order term.
- R3: Phit p (p = 0..3) occupies flit bits [20p+19:20p]. Its bits [17:0] carry content bits [18p+17:18p] and its bits [19:18] carry check bits [2p+1:2p].
- R4: `tx_out` and `tx_out_valid` are registered. `tx_out_valid` is 1 exactly in the cycle after a cycle with `tx_valid` high.
- R5: With `roll_en` high, the check field sent is R(n) XOR R(n-1), where R(n-1) is the remainder of the last flit sent in rolling mode. With `roll_en` low, the field is R(n).
- R6: Both histories are zero after reset and are cleared in every cycle with `roll_en` low. The first rolling flit after reset or after re-enabling the mode therefore carries its plain remainder.
- R7: One cycle after `rx_valid`, `rx_chk_valid` is 1 and `rx_err` is 1 exactly when the recomputed field (remainder XOR receive history in rolling mode) differs from the received check bits.
- R8: Any corruption of a flit is reported when it has weight 1, 2 or 3, has odd weight, or lies within 8 adjacent positions of the codeword order (content 71..0 then check 7..0).
- R9: The receive history is updated from the received check field, XORed with the old history, even when the flit fails. After a flit with corrupted content, the next clean flit passes.
- R10: In a cycle after one without `rx_valid`, `rx_chk_valid` and `rx_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| roll_en | input | 1 | Rolling check mode for both directions |
| tx_valid | input | 1 | Content to send is present |
| tx_flit | input | 72 | Content bits of the flit to send |
| tx_out_valid | output | 1 | Framed flit is present |
| tx_out | output | 80 | Framed flit with check bits |
| rx_valid | input | 1 | Received flit is present |
| rx_flit | input | 80 | Received framed flit |
| rx_chk_valid | output | 1 | Check result is present |
| rx_err | output | 1 | Check mismatch |

## Verification
The bench builds the block with its default parameters: four phits of 18 content and 2 check bits and the 8-bit polynomial. This gives the full 80-bit codeword, so single, double, triple, five-bit and 8-bit burst corruptions can be placed anywhere, including across phit boundaries and into the check field. Rolling chains, mode toggles and a reset in the middle of a chain are driven in sequence, so the history behaviour is seen at the ports.

// File: rtl/flit_crc_link.sv
module flit_crc_link #(
  parameter int PHITS = 4,
  parameter int PHIT_DATA = 18,
  parameter int PHIT_CRC = 2,
  localparam int CRC_W = PHITS * PHIT_CRC,
  localparam int CONTENT_W = PHITS * PHIT_DATA,
  localparam int PHIT_W = PHIT_DATA + PHIT_CRC,
  localparam int FLIT_W = PHITS * PHIT_W,
  parameter logic [CRC_W-1:0] POLY = 8'h85
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 roll_en,
  input  logic                 tx_valid,
  input  logic [CONTENT_W-1:0] tx_flit,
  output logic                 tx_out_valid,
  output logic [FLIT_W-1:0]    tx_out,
  input  logic                 rx_valid,
  input  logic [FLIT_W-1:0]    rx_flit,
  output logic                 rx_chk_valid,
  output logic                 rx_err
);

  function automatic logic [CRC_W-1:0] crc_calc(input logic [CONTENT_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = CONTENT_W - 1; i >= 0; i--)
      c = {c[CRC_W-2:0], 1'b0} ^ ((c[CRC_W-1] ^ d[i]) ? POLY : '0);
    return c;
  endfunction

  logic [CRC_W-1:0]     tx_hist, rx_hist;
  logic [CRC_W-1:0]     tx_rem, tx_field, rx_rem, rx_field, rx_expect;
  logic [CONTENT_W-1:0] rx_content, tx_out_content;
  logic [FLIT_W-1:0]    tx_word;

  assign tx_rem   = crc_calc(tx_flit);
  assign tx_field = tx_rem ^ (roll_en ? tx_hist : '0);

  genvar p;
  generate
    for (p = 0; p < PHITS; p++) begin : g_phit
      assign tx_word[p*PHIT_W +: PHIT_DATA]           = tx_flit[p*PHIT_DATA +: PHIT_DATA];
      assign tx_word[p*PHIT_W+PHIT_DATA +: PHIT_CRC]  = tx_field[p*PHIT_CRC +: PHIT_CRC];
      assign rx_content[p*PHIT_DATA +: PHIT_DATA]     = rx_flit[p*PHIT_W +: PHIT_DATA];
      assign rx_field[p*PHIT_CRC +: PHIT_CRC]         = rx_flit[p*PHIT_W+PHIT_DATA +: PHIT_CRC];
      assign tx_out_content[p*PHIT_DATA +: PHIT_DATA] = tx_out[p*PHIT_W +: PHIT_DATA];
    end
  endgenerate

  assign rx_rem    = crc_calc(rx_content);
  assign rx_expect = rx_rem ^ (roll_en ? rx_hist : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out_valid <= 1'b0;
      tx_out       <= '0;
      tx_hist      <= '0;
      rx_chk_valid <= 1'b0;
      rx_err       <= 1'b0;
      rx_hist      <= '0;
    end else begin
      tx_out_valid <= tx_valid;
      if (tx_valid) tx_out <= tx_word;
      if (!roll_en)      tx_hist <= '0;
      else if (tx_valid) tx_hist <= tx_rem;
      rx_chk_valid <= rx_valid;
      rx_err       <= rx_valid && (rx_expect != rx_field);
      if (!roll_en)      rx_hist <= '0;
      else if (rx_valid) rx_hist <= rx_field ^ rx_hist;
    end
  end

  // R4
  tx_valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> tx_out_valid);
  // R4
  tx_idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |=> !tx_out_valid);
  // R3
  tx_content_place_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> tx_out_content == $past(tx_flit));
  // R7
  rx_err_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    rx_err |-> rx_chk_valid);
  // R10
  rx_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !rx_chk_valid && !rx_err);
  // R6
  hist_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !roll_en |=> tx_hist == '0 && rx_hist == '0);

endmodule

// File: tb/flit_crc_link_test.sv
module flit_crc_link_test;
  logic clk = 1'b0;
  logic rst, roll_en, tx_valid, rx_valid;
  logic [71:0] tx_flit;
  logic [79:0] rx_flit, tx_out;
  logic tx_out_valid, rx_chk_valid, rx_err;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flit_crc_link uut (
    .clk(clk), .rst(rst), .roll_en(roll_en),
    .tx_valid(tx_valid), .tx_flit(tx_flit),
    .tx_out_valid(tx_out_valid), .tx_out(tx_out),
    .rx_valid(rx_valid), .rx_flit(rx_flit),
    .rx_chk_valid(rx_chk_valid), .rx_err(rx_err)
  );

  typedef struct packed {
    logic [71:0] f;
    logic        r;
    logic [79:0] m;
    logic        e;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{72'h0, 1'b0, 80'h0, 1'b0},
    '{72'hFF_FFFF_FFFF_FFFF_FFFF, 1'b0, 80'h0, 1'b0},
    '{72'h12_3456_789A_BCDE_F012, 1'b0, (80'd1 << 40), 1'b1},
    '{72'hA5_5A5A_A55A_A5A5_5AA5, 1'b0, (80'd1 << 79) | 80'd1, 1'b1},
    '{72'h00_0000_0000_0000_0001, 1'b0, (80'd1 << 77) | (80'd1 << 50) | (80'd1 << 3), 1'b1},
    '{72'h3C_C3F0_0F96_6987_1E2D, 1'b0, (80'hFF << 38), 1'b1},
    '{72'h01_0203_0405_0607_0809, 1'b1, 80'h0, 1'b0},
    '{72'hDE_ADBE_EF00_1122_3344, 1'b1, 80'h0, 1'b0},
    '{72'h55_AA55_AA55_AA55_AA55, 1'b1, (80'd1 << 9) | (80'd1 << 20) | (80'd1 << 33) | (80'd1 << 61) | (80'd1 << 70), 1'b1},
    '{72'h77_6655_4433_2211_0099, 1'b1, 80'h0, 1'b0},
    '{72'h0F_1E2D_3C4B_5A69_7887, 1'b1, (80'd1 << 2), 1'b1},
    '{72'hC0_FFEE_1234_5678_9ABC, 1'b0, 80'h0, 1'b0},
    '{72'h9A_8B7C_6D5E_4F30_2112, 1'b1, 80'h0, 1'b0},
    '{72'h44_3322_1100_FFEE_DDCC, 1'b1, (80'h7F << 4), 1'b1}
  };

  function automatic logic [7:0] ref_crc(input logic [71:0] f);
    logic [79:0] r;
    r = {f, 8'h00};
    for (int i = 79; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h185;
    return r[7:0];
  endfunction

  function automatic logic [79:0] ref_pack(input logic [71:0] f, input logic [7:0] c);
    logic [79:0] w;
    for (int p = 0; p < 4; p++) begin
      w[p*20 +: 18]    = f[p*18 +: 18];
      w[p*20+18 +: 2]  = c[p*2 +: 2];
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_tx(input logic [71:0] f, output logic [79:0] got);
    tx_valid = 1'b1;
    tx_flit  = f;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R4 out valid", {79'b0, tx_out_valid}, 80'd1);
    got = tx_out;
    @(negedge clk);
    chk("R4 out valid drops", {79'b0, tx_out_valid}, 80'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] h, c, fld;
    logic [79:0] got;
    rst = 1'b1; roll_en = 1'b0; tx_valid = 1'b0; rx_valid = 1'b0;
    tx_flit = '0; rx_flit = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {77'b0, tx_out_valid, rx_chk_valid, rx_err}, 80'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {77'b0, tx_out_valid, rx_chk_valid, rx_err}, 80'd0);
    h = 8'h00;

    for (int v = 0; v < NV; v++) begin
      roll_en = VEC[v].r;
      c = ref_crc(VEC[v].f);
      if (VEC[v].r) begin fld = c ^ h; h = c; end
      else begin fld = c; h = 8'h00; end
      send_tx(VEC[v].f, got);
      // R2 R3 R5 R6: framed flit with expected check field
      chk("R2/R3/R5 framed flit", got, ref_pack(VEC[v].f, fld));
      rx_valid = 1'b1;
      rx_flit  = got ^ ref_pack(VEC[v].m[79:8], VEC[v].m[7:0]);
      @(negedge clk);
      rx_valid = 1'b0;
      chk("R7 check valid", {79'b0, rx_chk_valid}, 80'd1);
      // R8 detection; R9 vector 9 passes after failed vector 8
      chk("R7/R8/R9 error flag", {79'b0, rx_err}, {79'b0, VEC[v].e});
      @(negedge clk);
      chk("R10 idle quiet", {78'b0, rx_chk_valid, rx_err}, 80'd0);
    end

    // R6: reset in the middle of a rolling chain
    roll_en = 1'b1;
    send_tx(72'h11_2233_4455_6677_8899, got);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset", {77'b0, tx_out_valid, rx_chk_valid, rx_err}, 80'd0);
    rst = 1'b0;
    send_tx(72'hAB_CDEF_0123_4567_89AB, got);
    chk("R6 history zero after reset", got, ref_pack(72'hAB_CDEF_0123_4567_89AB, ref_crc(72'hAB_CDEF_0123_4567_89AB)));

    // R6: mode toggled low for one idle cycle restarts the chain
    send_tx(72'h5A_5A5A_5A5A_5A5A_5A5A, got);
    roll_en = 1'b0;
    @(negedge clk);
    roll_en = 1'b1;
    send_tx(72'h01_0000_0000_0000_0080, got);
    chk("R6 history zero after mode toggle", got, ref_pack(72'h01_0000_0000_0000_0080, ref_crc(72'h01_0000_0000_0000_0080)));

    // R5: next flit chains onto the previous remainder
    send_tx(72'hFE_DCBA_9876_5432_10FE, got);
    chk("R5 rolling chain", got, ref_pack(72'hFE_DCBA_9876_5432_10FE,
        ref_crc(72'hFE_DCBA_9876_5432_10FE) ^ ref_crc(72'h01_0000_0000_0000_0080)));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule